// File: doc/BRIEF.md
# Receive descriptor ring writer

This block is the memory-facing half of a receive DMA engine. Software builds a ring of descriptors in memory. Each descriptor is two 32-bit words: a buffer address word, then a control/status word. Software hands every buffer to the engine by clearing the ownership flag, and marks the final descriptor of the ring with a wrap flag. Every buffer is 128 bytes, so bits 6:0 of the buffer address are taken as zero. A frame longer than one buffer runs on into as many following descriptors as it needs. It may pass over the wrap back to the ring base.

Incoming frames arrive as a byte stream with start and end markers and a valid/ready handshake. Before a buffer is used, the engine reads the descriptor's address word through a single memory port. It packs the bytes little-endian into 32-bit writes. When a buffer fills or the frame ends, the engine writes the status word. It then writes the address word back with the ownership flag set, which returns the buffer to software. If the next descriptor is still owned by software, the engine raises a ring-full flag and drops the rest of the frame. The ring base is loaded through a write strobe. The read pointer goes back to that base when the strobe is pulsed and each time reception is enabled.

The controller is one state machine with these states:
- IDLE: reception off.
- HUNT: wait for a frame start.
- FETCH: read the address word.
- CHECK: test ownership.
- RECV: store bytes.
- CLOSE: write the status word.
- MARK: write the address word back with ownership set.
- DROP: discard the bytes up to the frame end.

Its transitions are:
- enable (IDLE to HUNT)
- frame start (HUNT to FETCH)
- read issued (FETCH to CHECK)
- buffer free (CHECK to RECV)
- buffer owned (CHECK to DROP)
- buffer full or frame end (RECV to CLOSE)
- status done (CLOSE to MARK)
- continue (MARK to FETCH)
- frame done (MARK to HUNT)
- drop done (DROP to HUNT)
- disable or base write (any state to IDLE)

Top module: `rxr_desc_ring`

## Requirements
- R1: After reset, ring_full is 0, in_ready is 0 and no memory access is made.
- R2: Before a buffer is used, the descriptor's address word is read at the ring pointer. If its bit 0 (ownership) is 1, ring_full becomes 1, the frame is discarded without any memory write, and the pointer stays. A later fetch that finds bit 0 clear sets ring_full back to 0.
- R3: Frame bytes are written little-endian, with byte k of a buffer in lane k mod 4 of the word at buffer_base + 4*(k div 4). The buffer base is the address word with bits 6:0 forced to 0. A partial final word enables only the lanes that hold frame bytes.
- R4: A frame longer than 128 bytes continues into the next descriptors, filling 128 bytes per buffer. A frame of exactly 128 bytes uses one buffer.
- R5: Each used buffer gets its status word written at descriptor+4. Bit 14 is set in a frame's first buffer and bit 15 in its last. In the last buffer only, bits 11:0 hold the frame length modulo 4096 and bit 31 holds the broadcast input sampled with the end byte. All other bits are 0.
- R6: The status write is followed in the next cycle by a write of the original address word, with bit 0 set, to the descriptor's first word.
- R7: After a descriptor whose address word has bit 1 (wrap) set, the next descriptor is at the ring base. Otherwise it is 8 bytes further on.
- R8: A pulse on base_wr loads the ring base, returns the pointer to it, clears ring_full and abandons any frame in progress.
- R9: While waiting for a frame start, bytes without the start marker are accepted and discarded without memory writes. When rx_en is low, in_ready is 0 from the next cycle on.
- R10: Every write is word-aligned with byte enables 0001, 0011, 0111 or 1111, and no write occurs while ring_full is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Reception enable |
| base_wr | input | 1 | Ring base load strobe |
| base_addr | input | AW | Ring base byte address (8-byte aligned) |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte accepted this cycle |
| in_data | input | 8 | Stream byte |
| in_sof | input | 1 | Byte is first of a frame |
| in_eof | input | 1 | Byte is last of a frame |
| in_bcast | input | 1 | Frame has a broadcast destination (sampled with the end byte) |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the word accessed |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| ring_full | output | 1 | Next descriptor was owned and a frame was dropped |

## Verification
The bench builds the block with AW = 32 and BUF_BYTES = 128, over a four-descriptor ring. With so small a ring, a single frame of 300 bytes spans three buffers and reaches the wrap, and three frames are enough to exhaust the ring. One descriptor carries junk in address bits 6:2, so any failure to mask the buffer base shows up as a misplaced data write. Frame lengths of 3, 10, 128, 129 and 200 bytes cover partial words, an exact buffer fill and a one-byte spill across the wrap.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_FETCH,
        ST_CHECK,
        ST_RECV,
        ST_CLOSE,
        ST_MARK,
        ST_DROP
    } rxr_state_e;

    localparam int WORD_W     = 32;
    localparam int OWN_BIT    = 0;
    localparam int WRAP_BIT   = 1;
    localparam int SOF_BIT    = 14;
    localparam int EOF_BIT    = 15;
    localparam int BCAST_BIT  = 31;
    localparam int LEN_W      = 12;
    localparam int DESC_BYTES = 8;

endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
    parameter int AW         = 32,
    parameter int DESC_BYTES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_base,
    input  logic [AW-1:0] base_in,
    input  logic          restart,
    input  logic          advance,
    input  logic          wrap,
    output logic [AW-1:0] ptr
);

    logic [AW-1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            ptr    <= '0;
        end else if (load_base) begin
            base_q <= base_in;
            ptr    <= base_in;
        end else if (restart) begin
            ptr <= base_q;
        end else if (advance) begin
            ptr <= wrap ? base_q : ptr + AW'(DESC_BYTES);
        end
    end

endmodule

// File: rtl/rxr_lane_pack.sv
module rxr_lane_pack #(
    parameter int BUF_BYTES = 128,
    parameter int LEN_W     = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear_buf,
    input  logic                         clear_frame,
    input  logic                         take,
    input  logic [7:0]                   byte_in,
    output logic [$clog2(BUF_BYTES)-1:0] off,
    output logic [LEN_W-1:0]             flen,
    output logic [31:0]                  word_out,
    output logic [3:0]                   be_out,
    output logic                         last_lane,
    output logic                         buf_end
);

    localparam int OFF_W = $clog2(BUF_BYTES);

    logic [31:0] wq;
    logic [1:0]  lane;

    assign lane      = off[1:0];
    assign last_lane = (lane == 2'd3);
    assign buf_end   = (off == OFF_W'(BUF_BYTES - 1));

    always_comb begin
        word_out = wq;
        word_out[lane*8 +: 8] = byte_in;
        unique case (lane)
            2'd0:    be_out = 4'b0001;
            2'd1:    be_out = 4'b0011;
            2'd2:    be_out = 4'b0111;
            default: be_out = 4'b1111;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off  <= '0;
            flen <= '0;
            wq   <= '0;
        end else begin
            if (clear_buf) begin
                off <= '0;
            end else if (take) begin
                off <= off + 1'b1;
                wq[lane*8 +: 8] <= byte_in;
            end
            if (clear_frame) begin
                flen <= '0;
            end else if (take) begin
                flen <= flen + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rxr_desc_ring.sv
module rxr_desc_ring
    import rxr_pkg::*;
#(
    parameter int AW        = 32,
    parameter int BUF_BYTES = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          base_wr,
    input  logic [AW-1:0] base_addr,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [7:0]    in_data,
    input  logic          in_sof,
    input  logic          in_eof,
    input  logic          in_bcast,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [3:0]    mem_be,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          ring_full
);

    localparam int OFF_W = $clog2(BUF_BYTES);

    rxr_state_e state_q, state_d;

    logic [WORD_W-1:0] desc_q;
    logic              first_q, last_q, bcast_q, full_q;
    logic [LEN_W-1:0]  len_q;
    logic [AW-1:0]     ptr, buf_base;
    logic [OFF_W-1:0]  off;
    logic [LEN_W-1:0]  flen;
    logic [31:0]       pack_word;
    logic [3:0]        pack_be;
    logic              last_lane, buf_end, take, owned;
    logic [31:0]       status_word;

    assign owned     = mem_rdata[OWN_BIT];
    assign buf_base  = {desc_q[AW-1:OFF_W], {OFF_W{1'b0}}};
    assign take      = (state_q == ST_RECV) && in_valid;
    assign ring_full = full_q;

    rxr_ring_ptr #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_base (base_wr),
        .base_in   (base_addr),
        .restart   (state_q == ST_IDLE && rx_en && !base_wr),
        .advance   (state_q == ST_MARK),
        .wrap      (desc_q[WRAP_BIT]),
        .ptr       (ptr)
    );

    rxr_lane_pack #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_pack (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_buf   (state_q == ST_CHECK),
        .clear_frame (state_q == ST_HUNT),
        .take        (take),
        .byte_in     (in_data),
        .off         (off),
        .flen        (flen),
        .word_out    (pack_word),
        .be_out      (pack_be),
        .last_lane   (last_lane),
        .buf_end     (buf_end)
    );

    always_comb begin
        status_word = '0;
        status_word[SOF_BIT] = first_q;
        status_word[EOF_BIT] = last_q;
        if (last_q) begin
            status_word[LEN_W-1:0] = len_q;
            status_word[BCAST_BIT] = bcast_q;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (rx_en) state_d = ST_HUNT;
            ST_HUNT:  if (in_valid && in_sof) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_CHECK;
            ST_CHECK: state_d = owned ? ST_DROP : ST_RECV;
            ST_RECV:  if (take && (in_eof || buf_end)) state_d = ST_CLOSE;
            ST_CLOSE: state_d = ST_MARK;
            ST_MARK:  state_d = last_q ? ST_HUNT : ST_FETCH;
            ST_DROP:  if (in_valid && in_eof) state_d = ST_HUNT;
            default:  state_d = ST_IDLE;
        endcase
        if (!rx_en || base_wr) state_d = ST_IDLE;
    end

    // state register and frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            desc_q  <= '0;
            first_q <= 1'b0;
            last_q  <= 1'b0;
            bcast_q <= 1'b0;
            len_q   <= '0;
            full_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_HUNT:  first_q <= 1'b1;
                ST_FETCH: last_q  <= 1'b0;
                ST_CHECK: begin
                    full_q <= owned;
                    if (!owned) desc_q <= mem_rdata;
                end
                ST_RECV: if (take && in_eof) begin
                    last_q  <= 1'b1;
                    len_q   <= flen + 1'b1;
                    bcast_q <= in_bcast;
                end
                ST_MARK:  first_q <= 1'b0;
                default: ;
            endcase
            if (base_wr) full_q <= 1'b0;
        end
    end

    // output decode
    always_comb begin
        in_ready  = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr;
        mem_be    = 4'b0000;
        mem_wdata = '0;
        unique case (state_q)
            ST_HUNT:  in_ready = in_valid && !in_sof;
            ST_FETCH: mem_en = 1'b1;
            ST_RECV: begin
                in_ready  = 1'b1;
                mem_en    = take && (last_lane || in_eof);
                mem_we    = mem_en;
                mem_addr  = buf_base | AW'({off[OFF_W-1:2], 2'b00});
                mem_be    = pack_be;
                mem_wdata = pack_word;
            end
            ST_CLOSE: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr + AW'(4);
                mem_be    = 4'b1111;
                mem_wdata = status_word;
            end
            ST_MARK: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_be    = 4'b1111;
                mem_wdata = desc_q | 32'h1;
            end
            ST_DROP:  in_ready = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/rxr_desc_ring_chk.sv
module rxr_desc_ring_chk
    import rxr_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_en,
    input logic          base_wr,
    input logic          in_ready,
    input logic          mem_en,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [3:0]    mem_be,
    input logic [31:0]   mem_wdata,
    input logic          ring_full,
    input rxr_state_e    state_q
);

    AST_READY_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !in_ready); // R9

    AST_WRITE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> (mem_addr[1:0] == 2'b00)); // R3

    AST_BE_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> (mem_be inside {4'b0001, 4'b0011, 4'b0111, 4'b1111})); // R10

    AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ring_full |-> !(mem_en && mem_we)); // R2

    AST_MARK_AFTER_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLOSE && rx_en && !base_wr) |=>
            (mem_en && mem_we && mem_wdata[0] && mem_addr == $past(mem_addr) - AW'(4))); // R6

    AST_BASE_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr |=> !ring_full); // R8

endmodule

bind rxr_desc_ring rxr_desc_ring_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .base_wr   (base_wr),
    .in_ready  (in_ready),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .ring_full (ring_full),
    .state_q   (state_q)
);

// File: tb/rxr_desc_ring_tb.sv
module rxr_desc_ring_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 32;
    localparam int NDESC      = 4;
    localparam logic [31:0] RING_BASE = 32'h100;
    localparam logic [31:0] BUF0      = 32'h400;
    localparam int MEM_WORDS  = 512;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_en = 1'b0;
    logic          base_wr = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [7:0]    in_data = '0;
    logic          in_sof = 1'b0;
    logic          in_eof = 1'b0;
    logic          in_bcast = 1'b0;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [3:0]    mem_be;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          ring_full;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] mem [0:MEM_WORDS-1];

    // reference model state
    logic [31:0] dword [0:NDESC-1];
    bit          own_m [0:NDESC-1];
    int          mi = 0;
    bit          mfull = 0;
    logic [31:0] exp_addr [$];
    logic [31:0] exp_data [$];
    logic [3:0]  exp_be   [$];
    int          exp_kind [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rxr_desc_ring #(.AW(AW), .BUF_BYTES(128)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .base_wr(base_wr), .base_addr(base_addr),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof),
        .in_eof(in_eof), .in_bcast(in_bcast), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .ring_full(ring_full)
    );

    // memory with one-cycle read latency
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[10:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[10:2]];
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // every write is compared against the model's next expected write
    always @(negedge clk) begin
        if (rst_n && mem_en && mem_we) begin
            if (exp_addr.size() == 0) begin
                check(1'b0, "R9 unexpected write", mem_addr, 32'hFFFF_FFFF);
            end else begin
                logic [31:0] ea, ed, mask;
                logic [3:0]  eb;
                int k;
                string tag;
                ea = exp_addr.pop_front();
                ed = exp_data.pop_front();
                eb = exp_be.pop_front();
                k  = exp_kind.pop_front();
                tag = (k == 0) ? "R3 data" : (k == 1) ? "R5 status" : "R6 mark";
                mask = {{8{eb[3]}}, {8{eb[2]}}, {8{eb[1]}}, {8{eb[0]}}};
                check(mem_addr == ea, {tag, " addr (R7 ring order)"}, mem_addr, ea);
                check(mem_be == eb, {tag, " byte enables"}, {28'h0, mem_be}, {28'h0, eb});
                check((mem_wdata & mask) == (ed & mask), {tag, " data"}, mem_wdata & mask, ed & mask);
            end
        end
    end

    task automatic push(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be, input int kind);
        exp_addr.push_back(a);
        exp_data.push_back(d);
        exp_be.push_back(be);
        exp_kind.push_back(kind);
    endtask

    task automatic model_frame(input int len, input bit bc, input logic [7:0] seed);
        int rem = len;
        int pos = 0;
        bit first = 1;
        while (rem > 0) begin
            int n;
            bit last;
            logic [31:0] bbase, dadr, st;
            if (own_m[mi]) begin
                mfull = 1;
                return;
            end
            mfull = 0;
            n = (rem > 128) ? 128 : rem;
            last = (rem == n);
            bbase = dword[mi] & ~32'h7F;
            dadr = RING_BASE + 32'(8 * mi);
            for (int w = 0; w < (n + 3) / 4; w++) begin
                logic [31:0] d = '0;
                logic [3:0]  be = '0;
                for (int b = 0; b < 4; b++)
                    if (w * 4 + b < n) begin
                        d[b*8 +: 8] = seed + 8'(pos + w * 4 + b);
                        be[b] = 1'b1;
                    end
                push(bbase + 32'(4 * w), d, be, 0);
            end
            st = '0;
            st[14] = first;
            st[15] = last;
            if (last) begin
                st[11:0] = 12'(len);
                st[31] = bc;
            end
            push(dadr + 32'd4, st, 4'hF, 1);
            push(dadr, dword[mi] | 32'h1, 4'hF, 2);
            own_m[mi] = 1;
            dword[mi] = dword[mi] | 32'h1;
            mi = dword[mi][1] ? 0 : mi + 1;
            pos += n;
            rem -= n;
            first = 0;
        end
    endtask

    task automatic free_desc(input int k);
        own_m[k] = 0;
        dword[k] = dword[k] & ~32'h1;
        mem[(RING_BASE >> 2) + 2 * k] = dword[k];
    endtask

    task automatic drive_byte(input logic [7:0] d, input bit s, input bit e, input bit bc);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e; in_bcast = bc;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic send_frame(input int len, input bit bc, input logic [7:0] seed);
        model_frame(len, bc, seed);
        for (int k = 0; k < len; k++)
            drive_byte(seed + 8'(k), k == 0, k == len - 1, bc);
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic settle(input string req);
        repeat (6) @(negedge clk);
        check(exp_addr.size() == 0, {req, " all expected writes made"}, 32'(exp_addr.size()), 32'd0);
        check(ring_full == mfull, {req, " ring_full"}, {31'h0, ring_full}, {31'h0, mfull});
    endtask

    task automatic pulse_base();
        @(negedge clk);
        base_wr = 1'b1; base_addr = RING_BASE;
        @(negedge clk);
        base_wr = 1'b0;
        mi = 0;
        mfull = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
        for (int k = 0; k < NDESC; k++) begin
            dword[k] = BUF0 + 32'(128 * k);
            if (k == NDESC - 1) dword[k] = dword[k] | 32'h2;
            if (k == 1) dword[k] = dword[k] | 32'h7C;   // junk in bits 6:2
            own_m[k] = 0;
            mem[(RING_BASE >> 2) + 2 * k] = dword[k];
        end

        // R1: reset state
        repeat (3) @(negedge clk);
        check(!in_ready && !mem_en && !ring_full, "R1 reset outputs",
              {29'h0, in_ready, mem_en, ring_full}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        in_valid = 1'b1; in_sof = 1'b1;
        repeat (3) @(negedge clk);
        check(!in_ready && !mem_en, "R9 idle while disabled", {30'h0, in_ready, mem_en}, 32'h0);
        in_valid = 1'b0; in_sof = 1'b0;

        pulse_base();
        rx_en = 1'b1;

        send_frame(10, 1'b1, 8'h10);   settle("R5 short broadcast frame");
        send_frame(300, 1'b0, 8'h40);  settle("R4 multi-buffer frame through wrap R7");
        send_frame(128, 1'b0, 8'h80);  settle("R2 owned descriptor drops frame");
        check(ring_full == 1'b1, "R2 ring_full raised", {31'h0, ring_full}, 32'h1);

        pulse_base();
        settle("R8 base write clears ring_full");
        for (int k = 0; k < NDESC; k++) free_desc(k);

        send_frame(200, 1'b0, 8'h20);  settle("R4 two-buffer frame");
        for (int k = 0; k < 5; k++) drive_byte(8'hAA, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        settle("R9 stray bytes discarded");

        send_frame(128, 1'b1, 8'hC0);  settle("R4 exact 128-byte frame");
        free_desc(0);
        send_frame(129, 1'b0, 8'h05);  settle("R7 frame spills across wrap");
        send_frame(3, 1'b0, 8'h33);    settle("R2 full again on owned descriptor");
        free_desc(1);
        send_frame(3, 1'b1, 8'h66);    settle("R2 ring_full cleared by free fetch");

        pulse_base();
        for (int k = 0; k < NDESC; k++) free_desc(k);
        send_frame(4, 1'b1, 8'h90);    settle("R8 pointer back at ring base");

        rx_en = 1'b0;
        @(negedge clk);
        in_valid = 1'b1; in_sof = 1'b1;
        repeat (2) @(negedge clk);
        check(!in_ready, "R9 not ready when disabled", {31'h0, in_ready}, 32'h0);
        in_valid = 1'b0; in_sof = 1'b0;
        check(exp_addr.size() == 0, "R10 no leftover writes", 32'(exp_addr.size()), 32'd0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule